// File: doc/BRIEF.md
# Strobed RAM Cycle Sequencer

This controller sits between a simple request port and an asynchronous single-bit RAM that latches its address when the enable strobe goes low. A request carries an address, a write flag and a write bit, and uses a valid/ready handshake. The sequencer turns each request into an enable, write-enable, select and address/data waveform. Every interval in that waveform lasts at least the minimum the RAM needs. Each minimum is given in nanoseconds as a parameter. It is converted to whole clock cycles with a clock-period parameter, rounded up, and never allowed below one cycle.

Reads keep the sequencer's data driver off. The RAM output is captured on the clock edge that raises the enable, one cycle after the access time has run out. The captured bit comes back with a one-cycle done pulse. Writes also end with a done pulse.

When the data line is shared with the RAM output, the first write after a read waits one output-disable interval after the write strobe falls before it drives the line. A write that directly follows another write leaves the write strobe low across both cycles. That write needs no turnaround, and its data setup is counted against the rising enable, so its cycle is shorter.

Top module: `strobe_ram_seq`

## Requirements
- R1: After reset, enable, write strobe and select are high (inactive), the data driver is off, done is low and ready is high.
- R2: The address changes only on the edge that lowers the enable and stays constant while the enable is low. The enable stays low for at least the low-time count: 19 cycles for a read, 20 for a first write and 18 for a chained write with the default parameters.
- R3: Between two cycles the enable stays high for at least the high-time count. Two falling edges of the enable are at least the cycle-time count apart. Ready is high only when the sequencer is idle and both of these counts have been met.
- R4: The select output is low exactly while the enable is low.
- R5: A read holds the write strobe high and the data driver off. It captures the data line on the edge that raises the enable, and returns that bit with done exactly 19 cycles after acceptance (default parameters).
- R6: A write that follows a read or reset lowers the write strobe on the same edge as the enable. With a shared line, it drives data no earlier than the output-disable count (12 cycles) after that edge, so it never drives the line while the RAM still drives it.
- R7: Write data is driven and constant for at least the data-setup count before the enable rises. The driver stays on for one cycle after the rise and then turns off.
- R8: In a first write, the write strobe is low for at least the write-pulse count before the enable and select rise. Done follows 20 cycles after acceptance.
- R9: A write directly after a write keeps the write strobe low with no rising edge in between. It drives data from the enable's falling edge and finishes with done 18 cycles after acceptance.
- R10: A read accepted while the write strobe is low raises it on the edge that lowers the enable.
- R11: Done is a single-cycle pulse. It rises on the edge that raises the enable, for reads and writes alike.
- R12: A read returns the bit most recently written to that address through the sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | ADDR_W | Request address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 1 | Bit to write |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 1 | Bit read (valid with done after a read) |
| ram_en_n | output | 1 | RAM enable strobe, active low |
| ram_wr_n | output | 1 | RAM write strobe, active low |
| ram_sel_n | output | 1 | RAM select pair, active low |
| ram_addr | output | ADDR_W | RAM address |
| ram_dout | output | 1 | Data driven toward the RAM |
| ram_dout_oe | output | 1 | Driver enable for ram_dout |
| ram_din | input | 1 | Data line seen from the RAM side |

## Verification
The checker watches several rules on every cycle. It checks the enable low and high widths, the fall-to-fall spacing, address stability while the enable is low, and that select tracks the enable. It also checks that the driver stays off during reads, that the turnaround wait and the data-setup count are met before the rising enable, and that done is a single pulse. Other properties can only be shown by the bench's scenarios against a timed RAM model. These are that captured read data is truly valid and matches earlier writes, that no driver contention occurs on the shared line, that chained writes produce no write-strobe rise, and the exact done latency of each cycle kind.

// File: rtl/strobe_ram_seq_pkg.sv
`timescale 1ns/1ps
package strobe_ram_seq_pkg;

  typedef enum logic [0:0] {ST_IDLE, ST_LOW} seq_state_e;

  // Nanoseconds to whole clock cycles, rounded up, never below one.
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/strobe_ram_seq_tally.sv
`timescale 1ns/1ps
// Saturating interval counter: restart loads 1, saturates at MAXV.
module strobe_ram_seq_tally #(
  parameter int          W    = 5,
  parameter int unsigned MAXV = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)                 count <= W'(MAXV);
    else if (restart)        count <= W'(1);
    else if (count < W'(MAXV)) count <= count + W'(1);
  end
endmodule

// File: rtl/strobe_ram_seq_capture.sv
`timescale 1ns/1ps
// Read capture register and completion pulse.
module strobe_ram_seq_capture (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic is_read,
  input  logic din,
  output logic done,
  output logic rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      rdata <= 1'b0;
    end else begin
      done <= take;
      if (take && is_read) rdata <= din;
    end
  end
endmodule

// File: rtl/strobe_ram_seq.sv
`timescale 1ns/1ps
module strobe_ram_seq
  import strobe_ram_seq_pkg::*;
#(
  parameter int          ADDR_W     = 10,
  parameter int unsigned CLK_NS     = 10,
  parameter int unsigned T_AHLD_NS  = 40,   // address hold after enable falls
  parameter int unsigned T_ELO_NS   = 180,  // enable low width
  parameter int unsigned T_EHI_NS   = 100,  // enable high width
  parameter int unsigned T_CYC_NS   = 280,  // fall-to-fall cycle
  parameter int unsigned T_ACC_NS   = 180,  // access time from enable fall
  parameter int unsigned T_WPW_NS   = 100,  // write strobe low width
  parameter int unsigned T_WSU_NS   = 100,  // write strobe low before enable/select rise
  parameter int unsigned T_DSU_NS   = 80,   // data setup before terminating rise
  parameter int unsigned T_OFF_NS   = 120,  // RAM output disable after write strobe falls
  parameter bit          SHARED_BUS = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic              req_wdata,
  output logic              rsp_done,
  output logic              rsp_rdata,
  output logic              ram_en_n,
  output logic              ram_wr_n,
  output logic              ram_sel_n,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_dout,
  output logic              ram_dout_oe,
  input  logic              ram_din
);

  localparam int unsigned N_AH   = ns_to_cyc(T_AHLD_NS, CLK_NS);
  localparam int unsigned N_EL   = ns_to_cyc(T_ELO_NS, CLK_NS);
  localparam int unsigned N_EH   = ns_to_cyc(T_EHI_NS, CLK_NS);
  localparam int unsigned N_CYC  = ns_to_cyc(T_CYC_NS, CLK_NS);
  localparam int unsigned N_ACC  = ns_to_cyc(T_ACC_NS, CLK_NS) + 1; // one capture margin cycle
  localparam int unsigned N_WP   = ns_to_cyc(T_WPW_NS, CLK_NS);
  localparam int unsigned N_WSU  = ns_to_cyc(T_WSU_NS, CLK_NS);
  localparam int unsigned N_DS   = ns_to_cyc(T_DSU_NS, CLK_NS);
  localparam int unsigned N_TURN = SHARED_BUS ? ns_to_cyc(T_OFF_NS, CLK_NS) : 0;

  localparam int unsigned N_BASE = max2(N_EL, N_AH);
  localparam int unsigned N_RD   = max2(N_BASE, N_ACC);
  localparam int unsigned N_WF   = max2(N_BASE, max2(max2(N_WP, N_WSU), N_TURN + N_DS));
  localparam int unsigned N_WC   = max2(N_BASE, N_DS);
  localparam int unsigned N_LMAX = max2(N_RD, max2(N_WF, N_WC));
  localparam int unsigned N_TOP  = max2(N_LMAX, max2(N_EH, N_CYC));
  localparam int          CW     = $clog2(N_TOP + 1);

  localparam int unsigned TMAX [3] = '{N_LMAX, N_EH, N_CYC};

  seq_state_e    state;
  logic          cur_wr;
  logic          chain;
  logic          oe_drop;
  logic [CW-1:0] tcnt [3];   // 0: since enable fell, 1: since enable rose, 2: fall-to-fall
  logic [2:0]    trestart;
  logic [CW-1:0] low_target;
  logic          accept;
  logic          fin;

  assign req_ready = (state == ST_IDLE) && (tcnt[1] >= CW'(N_EH)) && (tcnt[2] >= CW'(N_CYC));
  assign accept    = req_valid && req_ready;

  always_comb begin
    if (!cur_wr)    low_target = CW'(N_RD);
    else if (chain) low_target = CW'(N_WC);
    else            low_target = CW'(N_WF);
  end

  assign fin      = (state == ST_LOW) && (tcnt[0] >= low_target);
  assign trestart = {accept, fin, accept};

  for (genvar g = 0; g < 3; g++) begin : g_tally
    strobe_ram_seq_tally #(.W(CW), .MAXV(TMAX[g])) u_tally (
      .clk     (clk),
      .rst     (rst),
      .restart (trestart[g]),
      .count   (tcnt[g])
    );
  end

  strobe_ram_seq_capture u_cap (
    .clk     (clk),
    .rst     (rst),
    .take    (fin),
    .is_read (!cur_wr),
    .din     (ram_din),
    .done    (rsp_done),
    .rdata   (rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      ram_en_n    <= 1'b1;
      ram_wr_n    <= 1'b1;
      ram_sel_n   <= 1'b1;
      ram_addr    <= '0;
      ram_dout    <= 1'b0;
      ram_dout_oe <= 1'b0;
      cur_wr      <= 1'b0;
      chain       <= 1'b0;
      oe_drop     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (oe_drop) begin
            ram_dout_oe <= 1'b0;
            oe_drop     <= 1'b0;
          end
          if (accept) begin
            state       <= ST_LOW;
            ram_en_n    <= 1'b0;
            ram_sel_n   <= 1'b0;
            ram_addr    <= req_addr;
            ram_dout    <= req_wdata;
            cur_wr      <= req_we;
            chain       <= req_we && !ram_wr_n;
            ram_wr_n    <= !req_we;
            ram_dout_oe <= req_we && (!ram_wr_n || (N_TURN == 0));
          end
        end
        ST_LOW: begin
          if (cur_wr && !chain && (tcnt[0] >= CW'(N_TURN)))
            ram_dout_oe <= 1'b1;
          if (fin) begin
            state     <= ST_IDLE;
            ram_en_n  <= 1'b1;
            ram_sel_n <= 1'b1;
            oe_drop   <= cur_wr;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/strobe_ram_seq_chk.sv
`timescale 1ns/1ps
module strobe_ram_seq_chk
  import strobe_ram_seq_pkg::*;
#(
  parameter int          ADDR_W     = 10,
  parameter int unsigned CLK_NS     = 10,
  parameter int unsigned T_ELO_NS   = 180,
  parameter int unsigned T_EHI_NS   = 100,
  parameter int unsigned T_CYC_NS   = 280,
  parameter int unsigned T_DSU_NS   = 80,
  parameter int unsigned T_OFF_NS   = 120,
  parameter bit          SHARED_BUS = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_done,
  input logic              ram_en_n,
  input logic              ram_wr_n,
  input logic              ram_sel_n,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_dout,
  input logic              ram_dout_oe
);
  localparam logic [15:0] C_EL  = 16'(ns_to_cyc(T_ELO_NS, CLK_NS));
  localparam logic [15:0] C_EH  = 16'(ns_to_cyc(T_EHI_NS, CLK_NS));
  localparam logic [15:0] C_CYC = 16'(ns_to_cyc(T_CYC_NS, CLK_NS));
  localparam logic [15:0] C_DS  = 16'(ns_to_cyc(T_DSU_NS, CLK_NS));
  localparam logic [15:0] C_OFF = 16'(ns_to_cyc(T_OFF_NS, CLK_NS));

  logic [15:0] lo_c, hi_c, cyc_c, wlo_c, oe_c;
  logic        e_q;

  function automatic logic [15:0] sat_inc(logic [15:0] v);
    return (v == 16'hFFFF) ? v : v + 16'd1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_c  <= '0;
      hi_c  <= 16'hFFFF;
      cyc_c <= 16'hFFFF;
      wlo_c <= '0;
      oe_c  <= '0;
      e_q   <= 1'b1;
    end else begin
      e_q   <= ram_en_n;
      lo_c  <= ram_en_n ? 16'd0 : sat_inc(lo_c);
      hi_c  <= ram_en_n ? sat_inc(hi_c) : 16'd0;
      cyc_c <= (e_q && !ram_en_n) ? 16'd1 : sat_inc(cyc_c);
      wlo_c <= ram_wr_n ? 16'd0 : sat_inc(wlo_c);
      oe_c  <= ram_dout_oe ? sat_inc(oe_c) : 16'd0;
    end
  end

  assert_elow_min_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_en_n) |-> lo_c >= C_EL);
  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (rst)
    (!ram_en_n && $past(!ram_en_n)) |-> $stable(ram_addr));
  assert_ehigh_min_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(ram_en_n) |-> hi_c >= C_EH);
  assert_cycle_min_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(ram_en_n) |-> cyc_c >= C_CYC);
  assert_ready_idle_R3: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (ram_en_n && ram_sel_n));
  assert_sel_tracks_R4: assert property (@(posedge clk) disable iff (rst)
    ram_sel_n == ram_en_n);
  assert_read_no_drive_R5: assert property (@(posedge clk) disable iff (rst)
    (!ram_en_n && ram_wr_n) |-> !ram_dout_oe);
  assert_turnaround_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(ram_dout_oe) && SHARED_BUS) |-> wlo_c >= C_OFF);
  assert_data_setup_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(ram_en_n) && !ram_wr_n) |-> (ram_dout_oe && oe_c >= C_DS));
  assert_data_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (ram_dout_oe && $past(ram_dout_oe) && !ram_en_n) |-> $stable(ram_dout));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);
  assert_done_at_rise_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_done) |-> $rose(ram_en_n));
endmodule

bind strobe_ram_seq strobe_ram_seq_chk #(
  .ADDR_W(ADDR_W), .CLK_NS(CLK_NS), .T_ELO_NS(T_ELO_NS), .T_EHI_NS(T_EHI_NS),
  .T_CYC_NS(T_CYC_NS), .T_DSU_NS(T_DSU_NS), .T_OFF_NS(T_OFF_NS), .SHARED_BUS(SHARED_BUS)
) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_done(rsp_done),
  .ram_en_n(ram_en_n), .ram_wr_n(ram_wr_n), .ram_sel_n(ram_sel_n),
  .ram_addr(ram_addr), .ram_dout(ram_dout), .ram_dout_oe(ram_dout_oe)
);

// File: tb/strobe_ram_seq_bench.sv
`timescale 1ns/1ps
module strobe_ram_seq_bench;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          req_we = 1'b0;
  logic          req_wdata = 1'b0;
  logic          rsp_done, rsp_rdata;
  logic          ram_en_n, ram_wr_n, ram_sel_n;
  logic [AW-1:0] ram_addr;
  logic          ram_dout, ram_dout_oe, ram_din;

  always #5 clk = ~clk;

  strobe_ram_seq u_strobe_ram_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .ram_en_n(ram_en_n), .ram_wr_n(ram_wr_n), .ram_sel_n(ram_sel_n),
    .ram_addr(ram_addr), .ram_dout(ram_dout), .ram_dout_oe(ram_dout_oe),
    .ram_din(ram_din)
  );

  int total = 0, fails = 0, contention = 0, w_rises = 0;
  bit mon = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int cyc(int ns);
    int c = (ns + 9) / 10;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(int a, int b); return (a > b) ? a : b; endfunction

  // expected low-time counts from the requirements
  function automatic int exp_rd(); return mx(mx(cyc(180), cyc(40)), cyc(180) + 1); endfunction
  function automatic int exp_wf(); return mx(mx(cyc(180), cyc(40)), mx(cyc(100), cyc(120) + cyc(80))); endfunction
  function automatic int exp_wc(); return mx(mx(cyc(180), cyc(40)), cyc(80)); endfunction

  // timed RAM model
  bit       mem [1024];
  bit       shadow [1024];
  logic [AW-1:0] lat;
  realtime  t_fall = 0, t_rise = 0, t_wfall = 0, t_dchg = 0, w_off = 0;
  bit       had_fall = 0, had_rise = 0;
  bit       drv_v = 0, val_v = 0, armed = 0;

  assign ram_din = ram_dout_oe ? ram_dout : (drv_v ? val_v : 1'b0);

  initial begin
    #0.5;
    forever begin
      drv_v = (!ram_en_n && !ram_sel_n && ram_wr_n) || ($realtime < w_off);
      val_v = (($realtime - t_fall) >= 180.0) ? mem[lat] : ~mem[lat];
      armed = !ram_en_n && !ram_sel_n && !ram_wr_n;
      if (mon && ram_dout_oe && drv_v) contention++;
      #1;
    end
  end

  always @(ram_dout_oe or ram_dout) t_dchg = $realtime;
  always @(posedge ram_wr_n) if (mon) w_rises++;
  always @(negedge ram_wr_n) begin
    t_wfall = $realtime;
    w_off   = $realtime + 120.0;
  end

  always @(negedge ram_en_n) if (mon) begin
    if (had_rise) chk(($realtime - t_rise) >= 100.0, "R3", "enable high ns", int'($realtime - t_rise), 100);
    if (had_fall) chk(($realtime - t_fall) >= 280.0, "R3", "fall-to-fall ns", int'($realtime - t_fall), 280);
    t_fall = $realtime; had_fall = 1;
    #0.1 lat = ram_addr;
  end

  always @(posedge ram_en_n) if (mon) begin
    chk(($realtime - t_fall) >= 180.0, "R2", "enable low ns", int'($realtime - t_fall), 180);
    if (armed) begin
      chk(ram_dout_oe && (($realtime - t_dchg) >= 80.0), "R7", "data setup ns", int'($realtime - t_dchg), 80);
      chk(($realtime - t_wfall) >= 100.0, "R8", "write strobe low ns", int'($realtime - t_wfall), 100);
      mem[lat] = ram_dout_oe ? ram_dout : ~shadow[lat];
    end
    t_rise = $realtime; had_rise = 1;
  end

  bit prev_we = 0;

  task automatic do_op(bit we, logic [AW-1:0] a, bit wd);
    int lat_c = 0;
    int exp_lat;
    bit chained = we && prev_we;
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(!ram_en_n && !ram_sel_n, "R4", "select low with enable", ram_sel_n, 0);
    chk(!req_ready, "R3", "ready low while busy", req_ready, 0);
    chk(ram_addr == a, "R2", "address at enable fall", ram_addr, a);
    if (!we) chk(ram_wr_n && !ram_dout_oe, "R5", "read strobe/driver", {ram_wr_n, ram_dout_oe}, 2);
    else if (chained) chk(!ram_wr_n && ram_dout_oe, "R9", "chained drives at once", {ram_wr_n, ram_dout_oe}, 1);
    else chk(!ram_wr_n && !ram_dout_oe, "R6", "fresh write turnaround", {ram_wr_n, ram_dout_oe}, 0);
    while (!rsp_done) begin @(negedge clk); lat_c++; end
    exp_lat = !we ? exp_rd() : (chained ? exp_wc() : exp_wf());
    if (!we) chk(lat_c == exp_lat, "R5", "read latency", lat_c, exp_lat);
    else if (chained) chk(lat_c == exp_lat, "R9", "chained write latency", lat_c, exp_lat);
    else chk(lat_c == exp_lat, "R8", "fresh write latency", lat_c, exp_lat);
    chk(ram_en_n && ram_sel_n, "R11", "done with enable rise", ram_en_n, 1);
    if (we) chk(ram_dout_oe, "R7", "driver held one cycle", ram_dout_oe, 1);
    if (!we) chk(rsp_rdata == shadow[a], "R12", "read data", rsp_rdata, shadow[a]);
    else shadow[a] = wd;
    @(negedge clk);
    chk(!rsp_done, "R11", "done single pulse", rsp_done, 0);
    if (we) chk(!ram_dout_oe, "R7", "driver off after hold", ram_dout_oe, 0);
    prev_we = we;
  endtask

  initial begin
    int wr0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(ram_en_n && ram_wr_n && ram_sel_n, "R1", "strobes idle", {ram_en_n, ram_wr_n, ram_sel_n}, 7);
    chk(!ram_dout_oe && !rsp_done, "R1", "driver off, done low", {ram_dout_oe, rsp_done}, 0);
    chk(req_ready, "R1", "ready after reset", req_ready, 1);
    mon = 1;
    do_op(1, 10'd5, 1);
    do_op(0, 10'd5, 0);
    wr0 = w_rises;
    do_op(1, 10'd0, 1);
    do_op(1, 10'd1023, 1);
    do_op(1, 10'd512, 0);
    chk(w_rises == wr0, "R9", "no strobe rise in chain", w_rises - wr0, 0);
    do_op(0, 10'd1023, 0);
    chk(w_rises == wr0 + 1, "R10", "strobe rose for read", w_rises - wr0, 1);
    do_op(0, 10'd0, 0);
    do_op(0, 10'd512, 0);
    for (int i = 0; i < 200; i++) begin
      bit we = $urandom_range(0, 1) == 1;
      logic [AW-1:0] a = ($urandom_range(0, 3) == 0) ? AW'($urandom) : AW'($urandom_range(0, 15));
      do_op(we, a, 1'($urandom));
    end
    chk(contention == 0, "R6", "shared line contention ticks", contention, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule